// File: doc/BRIEF.md
# Host Command/Data Mailbox Port

This block sits on the device side of a two-address byte port that a host drives over a simple I/O bus. Address 0 is the data register. Address 1 is the command register when written and the status register when read. Each host write lands in a one-byte input buffer. A flag marks whether the byte came through the command address or the data address. A local engine pops the bytes. Status flags pace the host: the input-buffer-full bit, plus one bit each for "ready for a command" and "ready for data".

A message runs as a fixed sequence. The host writes the start code to the command address and waits for the ready-for-data bit. It then writes payload bytes to the data address, each one only after the input buffer has drained, and closes with the end-of-command code. After the local engine pops that code, the port waits for a response. The engine pushes the response through a one-byte output buffer. The frame is a start marker, then the payload bytes, then an end marker. A status flag marks the two markers as control bytes. When the host reads the end marker, the port returns to idle. A cancel code written to the command address at any time abandons the exchange.

Top module: `mbox_port`

## Requirements
- R1: After reset the status register reads 0x10 (only ready-for-command set), both buffers are empty, and neither error flag is set.
- R2: Status bit positions: bit 0 output-buffer-full, bit 1 input-buffer-full, bit 2 control-byte flag, bit 3 last-write address, bit 4 ready for command, bit 5 ready for data, bits 7:6 zero. A read of address 0 returns the output buffer byte.
- R3: A host write that is accepted sets input-buffer-full. `in_is_cmd` is 1 for a byte written to address 1 and 0 for address 0. Status bit 3 follows the address of the latest host write. Input-buffer-full reads clear in the cycle after `in_pop`.
- R4: Popping command byte 0x01 while idle clears bit 4 and sets bit 5. Popping command byte 0x03 while receiving clears both bits, and the port then waits for a response.
- R5: A data write made while not receiving, or any write made while the input buffer is full, is dropped and sets the sticky `proto_err` flag.
- R6: A write of 0x22 to address 1 empties both buffers, clears the control flag and returns to idle. The status register reads 0x18 on the next cycle.
- R7: `rsp_ready` is high only while the port waits for a response and the output buffer is empty. `rsp_kind` selects the byte to load: 1 loads 0x01 with the control flag set, 0 loads `rsp_data` with the flag clear, and 2 loads 0x03 with the flag set. Each load sets output-buffer-full.
- R8: A host read of address 0 clears output-buffer-full and the control flag on the next cycle. Reading the end marker returns the port to idle.
- R9: When the end marker is loaded, `rsp_len_err` is set if the response carried fewer than 6 payload bytes, or if payload bytes 2 to 5, taken as a big-endian 32-bit value, differ from the payload count. Loading a start marker clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_we | input | 1 | Host write strobe |
| hst_re | input | 1 | Host read strobe |
| hst_addr | input | 1 | 0 data register, 1 command/status register |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte (combinational) |
| in_valid | output | 1 | Input buffer holds a byte |
| in_data | output | 8 | Input buffer byte |
| in_is_cmd | output | 1 | Input byte came through the command address |
| in_pop | input | 1 | Local engine takes the input byte |
| rsp_valid | input | 1 | Local engine offers a response byte |
| rsp_kind | input | 2 | 0 payload, 1 start marker, 2 end marker |
| rsp_data | input | 8 | Response payload byte |
| rsp_ready | output | 1 | Output buffer can take a byte |
| proto_err | output | 1 | Sticky dropped-write flag |
| rsp_len_err | output | 1 | Length check result of the last response |

## Verification
The bench builds the port with its default parameters: an 8-bit data path, a 16-bit saturating payload counter, and a minimum response length of 6. A 6-byte response whose length field reads 6 sits exactly on the boundary. A 7-byte response whose field still reads 6 fails only the length comparison. A 5-byte response fails the minimum check. The bench also puts a cancel in the middle of a receive sequence and drops writes both outside receive mode and onto a full buffer.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [7:0] CODE_START = 8'h01;
  localparam logic [7:0] CODE_EOC   = 8'h03;
  localparam logic [7:0] CODE_ABORT = 8'h22;

  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_RECV = 2'd1,
    M_BUSY = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    K_DATA  = 2'd0,
    K_START = 2'd1,
    K_END   = 2'd2
  } kind_e;

  function automatic logic [7:0] pack_status(input logic obf, input logic ibf,
                                             input logic f0, input logic a2,
                                             input logic rdy, input logic ibr);
    return {2'b00, ibr, rdy, a2, f0, ibf, obf};
  endfunction

  function automatic logic len_bad(input logic [31:0] cnt, input logic [31:0] len,
                                   input logic [31:0] min_len);
    return (cnt < min_len) || (len != cnt);
  endfunction
endpackage

// File: rtl/mbox_inbuf.sv
module mbox_inbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr_en,
  input  logic         wr_cmd,
  input  logic [W-1:0] wr_byte,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] byte_q,
  output logic         is_cmd,
  output logic         drop,
  output logic         pop_evt
);
  assign drop    = wr_en && full;
  assign pop_evt = pop && full && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      full   <= 1'b0;
      byte_q <= '0;
      is_cmd <= 1'b0;
    end else if (wr_en && !full) begin
      full   <= 1'b1;
      byte_q <= wr_byte;
      is_cmd <= wr_cmd;
    end else if (pop_evt) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cancel,
  input  logic         host_wr,
  input  logic         host_addr,
  input  logic         drop,
  input  logic         pop_evt,
  input  logic         pop_cmd,
  input  logic [W-1:0] pop_byte,
  input  logic         end_taken,
  output mode_e        mode,
  output logic         a2,
  output logic         proto_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= M_IDLE;
      a2        <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (host_wr) a2 <= host_addr;
      if (drop) proto_err <= 1'b1;
      if (cancel) begin
        mode <= M_IDLE;
      end else if (end_taken) begin
        mode <= M_IDLE;
      end else if (pop_evt && pop_cmd) begin
        if (pop_byte == CODE_START && mode == M_IDLE) mode <= M_RECV;
        else if (pop_byte == CODE_EOC && mode == M_RECV) mode <= M_BUSY;
      end
    end
  end
endmodule

// File: rtl/mbox_outbuf.sv
module mbox_outbuf
  import mbox_pkg::*;
#(
  parameter int W       = 8,
  parameter int CNT_W   = 16,
  parameter int MIN_LEN = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [1:0]   kind,
  input  logic [W-1:0] push_byte,
  input  logic         host_rd,
  output logic         obf,
  output logic         f0,
  output logic [W-1:0] byte_q,
  output logic         end_taken,
  output logic         len_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int               LEN_LO  = 2;
  localparam int               LEN_HI  = LEN_LO + 3;

  logic             hold_end;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      len;

  assign end_taken = host_rd && obf && hold_end && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      obf      <= 1'b0;
      f0       <= 1'b0;
      byte_q   <= '0;
      hold_end <= 1'b0;
    end else if (push) begin
      obf      <= 1'b1;
      f0       <= (kind != K_DATA);
      hold_end <= (kind == K_END);
      case (kind)
        K_START: byte_q <= W'(CODE_START);
        K_END:   byte_q <= W'(CODE_EOC);
        default: byte_q <= push_byte;
      endcase
    end else if (host_rd && obf) begin
      obf      <= 1'b0;
      f0       <= 1'b0;
      hold_end <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt     <= '0;
      len     <= '0;
      len_err <= 1'b0;
    end else if (push) begin
      case (kind)
        K_START: begin
          cnt     <= '0;
          len     <= '0;
          len_err <= 1'b0;
        end
        K_END: len_err <= len_bad(32'(cnt), len, 32'(MIN_LEN));
        default: begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (cnt >= CNT_W'(LEN_LO) && cnt <= CNT_W'(LEN_HI))
            len <= {len[23:0], 8'(push_byte)};
        end
      endcase
    end
  end
endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int W       = 8,
  parameter int CNT_W   = 16,
  parameter int MIN_LEN = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hst_we,
  input  logic         hst_re,
  input  logic         hst_addr,
  input  logic [W-1:0] hst_wdata,
  output logic [W-1:0] hst_rdata,
  output logic         in_valid,
  output logic [W-1:0] in_data,
  output logic         in_is_cmd,
  input  logic         in_pop,
  input  logic         rsp_valid,
  input  logic [1:0]   rsp_kind,
  input  logic [W-1:0] rsp_data,
  output logic         rsp_ready,
  output logic         proto_err,
  output logic         rsp_len_err
);
  mode_e      mode;
  logic       a2, obf, f0, end_taken;
  logic       wr_cmd, wr_dat, cancel, buf_wr, buf_drop, pop_evt, drop_evt;
  logic       push_evt, host_rd;
  logic [W-1:0] obuf;
  logic [7:0]   status;

  assign wr_cmd   = hst_we && hst_addr;
  assign wr_dat   = hst_we && !hst_addr;
  assign cancel   = wr_cmd && (hst_wdata == W'(CODE_ABORT));
  assign buf_wr   = (wr_dat && mode == M_RECV) || (wr_cmd && !cancel);
  assign drop_evt = (wr_dat && mode != M_RECV) || buf_drop;
  assign rsp_ready = !obf && (mode == M_BUSY);
  assign push_evt  = rsp_valid && rsp_ready && !cancel;
  assign host_rd   = hst_re && !hst_addr;

  assign status    = pack_status(obf, in_valid, f0, a2, mode == M_IDLE, mode == M_RECV);
  assign hst_rdata = hst_addr ? W'(status) : obuf;

  mbox_inbuf #(.W(W)) u_in (
    .clk(clk), .rst_n(rst_n), .flush(cancel),
    .wr_en(buf_wr), .wr_cmd(hst_addr), .wr_byte(hst_wdata),
    .pop(in_pop), .full(in_valid), .byte_q(in_data), .is_cmd(in_is_cmd),
    .drop(buf_drop), .pop_evt(pop_evt)
  );

  mbox_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cancel(cancel),
    .host_wr(hst_we), .host_addr(hst_addr), .drop(drop_evt),
    .pop_evt(pop_evt), .pop_cmd(in_is_cmd), .pop_byte(in_data),
    .end_taken(end_taken), .mode(mode), .a2(a2), .proto_err(proto_err)
  );

  mbox_outbuf #(.W(W), .CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_out (
    .clk(clk), .rst_n(rst_n), .flush(cancel),
    .push(push_evt), .kind(rsp_kind), .push_byte(rsp_data),
    .host_rd(host_rd), .obf(obf), .f0(f0), .byte_q(obuf),
    .end_taken(end_taken), .len_err(rsp_len_err)
  );
endmodule

// File: rtl/mbox_port_chk.sv
module mbox_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hst_we,
  input logic         hst_re,
  input logic         hst_addr,
  input logic [W-1:0] hst_wdata,
  input logic         in_valid,
  input logic         in_pop,
  input logic         rsp_ready,
  input logic         proto_err,
  input logic [7:0]   status
);
  AST_RDY_IBR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[4] && status[5])) else $error("rdy/ibr both set"); // R4
  AST_POP_CLEARS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pop) |=> !in_valid) else $error("ibf stuck"); // R3
  AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_we && hst_addr && hst_wdata == W'(8'h22)) |=> (status == 8'h18)) else $error("cancel"); // R6
  AST_READ_CLEARS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_re && !hst_addr && status[0]) |=> !status[0]) else $error("obf stuck"); // R8
  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_we && !hst_addr && !status[5]) |=> proto_err) else $error("drop flag"); // R5
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err) else $error("err not sticky"); // R5
  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !status[0]) else $error("ready while full"); // R7
  AST_F0_NEEDS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> status[0]) else $error("f0 without obf"); // R7
endmodule

bind mbox_port mbox_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_re(hst_re),
  .hst_addr(hst_addr), .hst_wdata(hst_wdata), .in_valid(in_valid),
  .in_pop(in_pop), .rsp_ready(rsp_ready), .proto_err(proto_err),
  .status(status)
);

// File: tb/test_mbox_port.sv
module test_mbox_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hst_we = 0, hst_re = 0, hst_addr = 0;
  logic [7:0] hst_wdata = 0, hst_rdata;
  logic       in_valid, in_is_cmd, in_pop = 0;
  logic [7:0] in_data;
  logic       rsp_valid = 0;
  logic [1:0] rsp_kind = 0;
  logic [7:0] rsp_data = 0;
  logic       rsp_ready, proto_err, rsp_len_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_port i_mbox_port (
    .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_re(hst_re),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_is_cmd(in_is_cmd),
    .in_pop(in_pop), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_data(rsp_data), .rsp_ready(rsp_ready), .proto_err(proto_err),
    .rsp_len_err(rsp_len_err)
  );

  // {op(0 write,1 pop), addr, byte, expected status after}
  localparam logic [18:0] VEC [8] = '{
    {2'd0, 1'b1, 8'h01, 8'h1A},
    {2'd1, 1'b0, 8'h00, 8'h28},
    {2'd0, 1'b0, 8'hAB, 8'h22},
    {2'd1, 1'b0, 8'h00, 8'h20},
    {2'd0, 1'b0, 8'hCD, 8'h22},
    {2'd1, 1'b0, 8'h00, 8'h20},
    {2'd0, 1'b1, 8'h03, 8'h2A},
    {2'd1, 1'b0, 8'h00, 8'h08}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic a, input logic [7:0] d);
    @(negedge clk); hst_we = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_we = 0;
  endtask

  task automatic pop_one();
    @(negedge clk); in_pop = 1;
    @(negedge clk); in_pop = 0;
  endtask

  task automatic rd_data(output logic [7:0] v);
    @(negedge clk); hst_re = 1; hst_addr = 0; #1 v = hst_rdata;
    @(negedge clk); hst_re = 0;
  endtask

  task automatic get_status(output logic [7:0] v);
    hst_addr = 1; #1 v = hst_rdata;
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk); rsp_valid = 1; rsp_kind = k; rsp_data = d;
    @(negedge clk); rsp_valid = 0;
  endtask

  task automatic to_busy();
    host_wr(1, 8'h01); pop_one();
    host_wr(1, 8'h03); pop_one();
  endtask

  task automatic respond(input int n, input logic [31:0] len_field);
    logic [7:0] v;
    push(2'd1, 8'h00); rd_data(v);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = (i >= 2 && i <= 5) ? len_field[8*(5-i) +: 8] : 8'(i + 8'h40);
      push(2'd0, b); rd_data(v);
    end
    push(2'd2, 8'h00); rd_data(v);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] s, v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    get_status(s);
    check(s, 8'h10, "R1 reset status");
    check({in_valid, proto_err, rsp_len_err, rsp_ready}, 0, "R1 reset flags");

    for (int i = 0; i < 8; i++) begin
      if (VEC[i][18:17] == 2'd0) host_wr(VEC[i][16], VEC[i][15:8]);
      else pop_one();
      get_status(s);
      check(s, VEC[i][7:0], $sformatf("R2 R3 R4 vector %0d", i));
    end

    // R7: response frame; status bit 2 flags markers
    check(rsp_ready, 1, "R7 ready while waiting");
    push(2'd1, 8'h99);
    get_status(s);
    check(s, 8'h0D, "R7 start marker status");
    check(rsp_ready, 0, "R7 ready low when full");
    rd_data(v);
    check(v, 8'h01, "R2 R7 start marker byte");
    get_status(s);
    check(s, 8'h08, "R8 read clears obf");
    push(2'd0, 8'h00); get_status(s);
    check(s, 8'h09, "R7 payload f0 clear");
    rd_data(v); check(v, 8'h00, "R7 payload byte");
    push(2'd0, 8'hC4); rd_data(v); check(v, 8'hC4, "R7 payload byte 1");
    for (int i = 2; i < 6; i++) begin
      push(2'd0, (i == 5) ? 8'h06 : 8'h00); rd_data(v);
    end
    push(2'd2, 8'h00); get_status(s);
    check(s, 8'h0D, "R7 end marker status");
    check(rsp_len_err, 0, "R9 six bytes length six ok");
    rd_data(v); check(v, 8'h03, "R7 end marker byte");
    get_status(s);
    check(s, 8'h18, "R8 end read returns idle");

    // R9 mismatch and short
    to_busy(); respond(7, 32'd6);
    check(rsp_len_err, 1, "R9 seven bytes field six");
    to_busy(); push(2'd1, 0);
    check(rsp_len_err, 0, "R9 cleared by start");
    rd_data(v);
    for (int i = 0; i < 5; i++) begin push(2'd0, 8'h00); rd_data(v); end
    push(2'd2, 0); rd_data(v);
    check(rsp_len_err, 1, "R9 five bytes too short");
    to_busy(); respond(8, 32'd8);
    check(rsp_len_err, 0, "R9 eight bytes field eight");

    // R3 data popped carries address flag
    host_wr(1, 8'h01);
    check({in_valid, in_is_cmd, in_data}, {2'b11, 8'h01}, "R3 command byte flagged");
    pop_one();
    host_wr(0, 8'h5A);
    check({in_valid, in_is_cmd, in_data}, {2'b10, 8'h5A}, "R3 data byte flagged");
    // R5 overrun while full
    check(proto_err, 0, "R5 no error yet");
    host_wr(0, 8'h77);
    check({proto_err, in_data}, {1'b1, 8'h5A}, "R5 overrun dropped");
    // R6 cancel mid-receive
    host_wr(1, 8'h22);
    get_status(s);
    check(s, 8'h18, "R6 cancel to idle");
    check(in_valid, 0, "R6 cancel empties input");
    // R5 data in idle dropped
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    host_wr(0, 8'h11);
    get_status(s);
    check({proto_err, s}, {1'b1, 8'h10}, "R5 idle data write dropped");
    check(rsp_ready, 0, "R7 not ready in idle");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule